// File: doc/BRIEF.md
# Host Configuration Serial Port

This block is a slave serial port through which a host processor sets up a three-channel line interface. The host drives an active-low select, a serial clock and a serial data input. The block returns read data on a serial output and gives a separate enable for the output's tri-state driver. Behind the port is a register file of five 8-bit command registers for each of the three channels, fifteen in all. Every bit of every register is brought out on a flat configuration bus, where the channel logic uses it.

All port pins are asynchronous to the block clock. They pass through a two-stage synchronizer, and the serial clock edges are then found in the block clock domain. A frame carries a direction bit, then a seven-bit register address, then eight data bits. A write loads the addressed register when its last data bit is sampled. A read shifts the addressed register out during the data phase. A level-sensitive register-reset input forces all fifteen registers back to their power-up values for as long as it is held low.

Top module: `hsif_top`

## Requirements
- R1: After `rst_n` is released, `host_sdo_en` is low and every register holds its default value. The defaults are 0x81, 0x10, 0x00, 0x40 and 0x03 for register index 0, 1, 2, 3 and 4 of each channel.
- R2: A frame is sent MSB first and sampled on rising serial clock edges. Bit 15 is the direction bit (0 = write, 1 = read). Bits 14..8 are the address {2'b00, channel[1:0], register[2:0]}. Bits 7..0 are the data. On a write, channel c register r appears on `cfg_bits[(c*5+r)*8 +: 8]`.
- R3: On a read, the addressed register is driven on `host_sdo` MSB first. Each bit is launched on a falling serial clock edge, starting with the falling edge after the 8th rising edge, so the host samples it on rising edges 9 to 16.
- R4: `host_sdo_en` is high only during the data phase of a read. It drops after the falling edge that follows the 16th rising edge, and within one clock of select going high.
- R5: A write frame that ends, with select going high, before its 16th rising edge changes no register.
- R6: A read of an unmapped address returns all zeros. A write to an unmapped address changes no register. An address is unmapped when bits 6..5 are not zero, the channel field is 3, or the register field is 5 or more.
- R7: While `reg_rst_n` is held low, all fifteen registers return to the defaults of R1.
- R8: Serial clock edges beyond the 16th in one frame are ignored, so a frame with extra clocks writes exactly its first data byte.
- R9: `host_sdo_en` stays low for the whole of a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least six times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reg_rst_n | input | 1 | Active-low level register reset, asynchronous to `clk` |
| host_cs_n | input | 1 | Active-low frame select |
| host_sclk | input | 1 | Serial clock, idle low |
| host_sdi | input | 1 | Serial data from the host |
| host_sdo | output | 1 | Serial read data to the host |
| host_sdo_en | output | 1 | Drive enable for the serial output pad |
| cfg_bits | output | 120 | All command registers, channel-major, 8 bits each |

## Verification
The assertions assume three things about the pins. The serial clock is idle low whenever select changes. Each serial clock phase lasts several block clocks, so no rising and falling edge fall within one synchronized sample. The data input is stable around each rising edge. The bench keeps to these rules by driving all pins from the falling block clock edge and holding each serial phase for six block clocks. Within that envelope it draws random addresses, including unmapped ones, random directions and data, and occasional register-reset pulses, mixed with directed aborted, overlong and boundary-address frames.

// File: rtl/hsif_pkg.sv
package hsif_pkg;
    localparam int NCH        = 3;
    localparam int NREG       = 5;
    localparam int DW         = 8;
    localparam int AW         = 7;
    localparam int HDR_BITS   = 1 + AW;
    localparam int FRAME_BITS = HDR_BITS + DW;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int NSLOT      = NCH * NREG;
    localparam int CFG_W      = NSLOT * DW;

    typedef struct packed {
        logic             sclk_prev;
        logic [CNT_W-1:0] cnt;
        logic [AW:0]      hdr;
        logic [DW-2:0]    wsh;
        logic [DW-1:0]    rsh;
        logic             sdo;
        logic             oe;
        logic             wr;
        logic [DW-1:0]    wdata;
    } frame_st_t;

    function automatic logic addr_ok(input logic [AW-1:0] a);
        return (a[6:5] == 2'b00) && (int'(a[4:3]) < NCH) && (int'(a[2:0]) < NREG);
    endfunction

    function automatic int slot_of(input logic [AW-1:0] a);
        return int'(a[4:3]) * NREG + int'(a[2:0]);
    endfunction
endpackage

// File: rtl/hsif_sync.sv
module hsif_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsif_frame.sv
module hsif_frame
    import hsif_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_i,
    input  logic          sclk_i,
    input  logic          sdi_i,
    input  logic [DW-1:0] rdata_i,
    output logic [AW-1:0] addr_o,
    output logic          wr_o,
    output logic [DW-1:0] wdata_o,
    output logic          sdo_o,
    output logic          sdo_oe_o
);
    localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS);

    frame_st_t q, n;
    logic rise, fall;

    always_comb begin
        n           = q;
        n.wr        = 1'b0;
        n.sclk_prev = sclk_i;
        rise        = sclk_i && !q.sclk_prev;
        fall        = !sclk_i && q.sclk_prev;
        if (cs_n_i) begin
            n.cnt = '0;
            n.hdr = '0;
            n.oe  = 1'b0;
            n.sdo = 1'b0;
        end else begin
            if (rise && (q.cnt < LAST_CNT)) begin
                n.cnt = q.cnt + 1'b1;
                if (q.cnt < HDR_CNT) begin
                    n.hdr = {q.hdr[AW-1:0], sdi_i};
                end else begin
                    n.wsh = {q.wsh[DW-3:0], sdi_i};
                    if ((q.cnt == LAST_CNT - 1'b1) && !q.hdr[AW]) begin
                        n.wr    = 1'b1;
                        n.wdata = {q.wsh, sdi_i};
                    end
                end
            end
            if (fall && q.hdr[AW] && (q.cnt >= HDR_CNT)) begin
                if (q.cnt == HDR_CNT) begin
                    n.sdo = rdata_i[DW-1];
                    n.rsh = {rdata_i[DW-2:0], 1'b0};
                    n.oe  = 1'b1;
                end else if (q.cnt < LAST_CNT) begin
                    n.sdo = q.rsh[DW-1];
                    n.rsh = {q.rsh[DW-2:0], 1'b0};
                end else begin
                    n.sdo = 1'b0;
                    n.oe  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign addr_o   = q.hdr[AW-1:0];
    assign wr_o     = q.wr;
    assign wdata_o  = q.wdata;
    assign sdo_o    = q.sdo;
    assign sdo_oe_o = q.oe;

    // R4: deselect turns the output driver off on the next clock
    p_oe_off_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !sdo_oe_o);
    // R9: the driver is only ever enabled for a read header
    p_oe_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o |-> q.hdr[AW]);
    // R3: read data moves only on a falling serial edge
    p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o && !fall && !cs_n_i) |=> $stable(sdo_o));
    // R2: one write strobe per frame
    p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);
endmodule

// File: rtl/hsif_regfile.sv
module hsif_regfile
    import hsif_pkg::*;
#(
    parameter logic [NREG*DW-1:0] REG_DEFAULT = 40'h03_40_00_10_81
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_n_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic [CFG_W-1:0] cfg_o
);
    logic [DW-1:0] regs_q [NSLOT];
    logic [DW-1:0] regs_d [NSLOT];
    logic          hit;

    function automatic logic [DW-1:0] dflt(input int s);
        return REG_DEFAULT[(s % NREG)*DW +: DW];
    endfunction

    always_comb begin
        hit = addr_ok(addr_i);
        for (int s = 0; s < NSLOT; s++) begin
            regs_d[s] = regs_q[s];
        end
        if (!clear_n_i) begin
            for (int s = 0; s < NSLOT; s++) begin
                regs_d[s] = dflt(s);
            end
        end else if (wr_i && hit) begin
            regs_d[slot_of(addr_i)] = wdata_i;
        end
        rdata_o = hit ? regs_q[slot_of(addr_i)] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) regs_q[s] <= dflt(s);
        end else begin
            for (int s = 0; s < NSLOT; s++) regs_q[s] <= regs_d[s];
        end
    end

    genvar c, r;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            for (r = 0; r < NREG; r++) begin : g_reg
                assign cfg_o[(c*NREG + r)*DW +: DW] = regs_q[c*NREG + r];
            end
        end
    endgenerate

    // R5: no strobe, no register change
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && clear_n_i) |=> $stable(cfg_o));
    // R6: unmapped writes leave everything as it was
    p_unmapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !addr_ok(addr_i) && clear_n_i) |=> $stable(cfg_o));
    // R7: register reset restores the defaults
    p_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n_i |=> (cfg_o == {NCH{REG_DEFAULT}}));
endmodule

// File: rtl/hsif_top.sv
module hsif_top
    import hsif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_rst_n,
    input  logic             host_cs_n,
    input  logic             host_sclk,
    input  logic             host_sdi,
    output logic             host_sdo,
    output logic             host_sdo_en,
    output logic [CFG_W-1:0] cfg_bits
);
    logic [3:0]    pins_s;
    logic [AW-1:0] addr;
    logic          wr;
    logic [DW-1:0] wdata, rdata;

    hsif_sync #(.WIDTH(4), .STAGES(2), .RST_VAL(4'b1100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({reg_rst_n, host_cs_n, host_sclk, host_sdi}),
        .sync_o  (pins_s)
    );

    hsif_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (pins_s[2]),
        .sclk_i   (pins_s[1]),
        .sdi_i    (pins_s[0]),
        .rdata_i  (rdata),
        .addr_o   (addr),
        .wr_o     (wr),
        .wdata_o  (wdata),
        .sdo_o    (host_sdo),
        .sdo_oe_o (host_sdo_en)
    );

    hsif_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_n_i (pins_s[3]),
        .wr_i      (wr),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .cfg_o     (cfg_bits)
    );
endmodule

// File: tb/hsif_top_bench.sv
module hsif_top_bench;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0, reg_rst_n = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_en;
    logic [119:0] cfg;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] model [15];

    always #2.5 clk = ~clk;

    hsif_top u_hsif_top (
        .clk(clk), .rst_n(rst_n), .reg_rst_n(reg_rst_n),
        .host_cs_n(cs_n), .host_sclk(sclk), .host_sdi(sdi),
        .host_sdo(sdo), .host_sdo_en(sdo_en), .cfg_bits(cfg)
    );

    function automatic logic [7:0] dflt(input int r);
        case (r)
            0: return 8'h81;
            1: return 8'h10;
            2: return 8'h00;
            3: return 8'h40;
            default: return 8'h03;
        endcase
    endfunction

    function automatic bit mapped(input logic [6:0] a);
        return a[6:5] == 2'b00 && a[4:3] != 2'b11 && a[2:0] < 3'd5;
    endfunction

    function automatic int slot(input logic [6:0] a);
        return int'(a[4:3]) * 5 + int'(a[2:0]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 15; s++) model[s] = dflt(s % 5);
    endtask

    task automatic check_all(input string tag);
        for (int s = 0; s < 15; s++) chk(tag, 32'(cfg[s*8 +: 8]), 32'(model[s]));
    endtask

    task automatic xfer(input logic [15:0] frm, input int nbits,
                        output logic [7:0] rd, output bit oe_bad, output logic oe_end);
        rd = '0;
        oe_bad = 0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? frm[15-i] : 1'b1;
            repeat (H) @(negedge clk);
            if (i >= 8 && i < 16) begin
                rd[15-i] = sdo;
                if (sdo_en !== frm[15]) oe_bad = 1;
            end else if (sdo_en !== 1'b0) oe_bad = 1;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        oe_end = sdo_en;
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
        if (sdo_en !== 1'b0) oe_bad = 1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string tag);
        logic [7:0] rd; bit bad; logic oe_end;
        xfer({1'b0, a, d}, 16, rd, bad, oe_end);
        chk({tag, " R9 driver during write"}, 32'(bad), 0);
        if (mapped(a)) model[slot(a)] = d;
    endtask

    task automatic do_read(input logic [6:0] a, input string tag);
        logic [7:0] rd; bit bad; logic oe_end;
        xfer({1'b1, a, 8'h00}, 16, rd, bad, oe_end);
        chk({tag, " R3/R6 read data"}, 32'(rd), 32'(mapped(a) ? model[slot(a)] : 8'h00));
        chk({tag, " R4 enable window"}, 32'(bad), 0);
        chk({tag, " R4 enable off after frame"}, 32'(oe_end), 0);
    endtask

    initial begin
        logic [7:0] rd; bit bad; logic oe_end;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 sdo_en after reset", 32'(sdo_en), 0);
        check_all("R1 default");
        // R2/R3 boundary addresses
        do_write(7'h14, 8'hA5, "R2 ch2 reg4");
        check_all("R2 layout ch2 reg4");
        do_write(7'h00, 8'h5A, "R2 ch0 reg0");
        check_all("R2 layout ch0 reg0");
        do_read(7'h14, "R3 ch2 reg4");
        do_read(7'h00, "R3 ch0 reg0");
        do_read(7'h0B, "R3 ch1 reg3");
        // R5 aborted writes
        xfer({1'b0, 7'h09, 8'hFF}, 15, rd, bad, oe_end);
        check_all("R5 abort after 15 bits");
        xfer({1'b0, 7'h02, 8'h3C}, 4, rd, bad, oe_end);
        check_all("R5 abort in header");
        // R4 aborted read drops the driver
        xfer({1'b1, 7'h14, 8'h00}, 11, rd, bad, oe_end);
        chk("R4 aborted read enable while selected", 32'(oe_end), 1);
        chk("R4 aborted read enable after deselect", 32'(bad), 0);
        // R8 extra clocks
        xfer({1'b0, 7'h0A, 8'h96}, 21, rd, bad, oe_end);
        model[slot(7'h0A)] = 8'h96;
        check_all("R8 overlong write");
        chk("R8 R9 driver in overlong write", 32'(bad), 0);
        // R6 unmapped
        do_write(7'h18, 8'hEE, "R6 channel 3");
        do_write(7'h05, 8'hEE, "R6 register 5");
        do_write(7'h7F, 8'hEE, "R6 high bits");
        check_all("R6 unmapped writes");
        do_read(7'h18, "R6 channel 3");
        do_read(7'h27, "R6 high bits");
        // R7 register reset
        reg_rst_n = 1'b0;
        repeat (6) @(negedge clk);
        reg_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        model_reset();
        check_all("R7 register reset");
        // random mix
        for (int k = 0; k < 70; k++) begin
            int unsigned pick;
            logic [6:0] a;
            pick = $urandom % 12;
            if (pick == 0) begin
                reg_rst_n = 1'b0;
                repeat (5) @(negedge clk);
                reg_rst_n = 1'b1;
                repeat (4) @(negedge clk);
                model_reset();
                check_all("R7 random register reset");
            end else begin
                if ($urandom % 6 == 0) a = 7'($urandom % 128);
                else a = {2'b00, 2'($urandom % 3), 3'($urandom % 5)};
                if ($urandom % 2 == 0) begin
                    do_write(a, 8'($urandom), "R2 random write");
                    check_all("R2 R6 random write effect");
                end else begin
                    do_read(a, "R3 random read");
                end
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule